// File: doc/BRIEF.md
# Exception Handler Chain Unwinder

This block performs the hardware part of raising an exception on a stack-oriented processor. Every active subprogram owns a small record in stack memory that holds two words: the address of the handler for that subprogram and a pointer to the record of the enclosing scope. A chain register (ER) always points at the innermost record. When an exception is raised, the block walks one link of that chain over a single-port stack memory. It moves the stack pointer to the record, pops the handler address into the program counter, and pops the outer link into ER. It then pushes the exception number, so the handler finds the number on top of the stack.

Both hardware-detected faults and software-raised exceptions start the same fixed sequence. The stack grows toward lower addresses. A pop reads the word at SP and then increments SP. A push decrements SP and then writes. Memory read data returns one cycle after the request. The sequence therefore takes a constant number of cycles. Raising an exception while ER is zero means no handler record exists, so the block flags a fatal error instead of unwinding.

Top module: `exc_unwind`

## Requirements
- R1: After reset, pc_o, er_o and sp_o are zero, and busy_o, done_o, fatal_o and mem_req_o are low.
- R2: In the cycle after an accepted raise with a nonzero ER, sp_o equals the previous ER value and busy_o is high.
- R3: The first memory read of the sequence is at the old ER address, and its returned word becomes pc_o.
- R4: The second read is at old ER + 1, and its returned word becomes the new er_o.
- R5: The sequence ends with one write of the zero-extended exception number at address old ER + 1. The final sp_o is old ER + 1, and each sequence makes exactly three memory requests.
- R6: busy_o stays high for exactly 4 cycles after the raise is accepted. done_o pulses for one cycle as busy_o falls.
- R7: A raise while ER is zero makes no memory request and leaves pc_o, er_o and sp_o unchanged. It sets fatal_o, which stays high until reset.
- R8: A raise request arriving while busy_o is high is ignored, and the running sequence pushes its own number.
- R9: sp_ld_i and er_ld_i copy ld_val_i into SP or ER when idle, and they have no effect while busy_o is high.
- R10: Requests come from either the hardware source (hw_req_i) or the software source (sw_req_i). When both assert in the same idle cycle, the hardware number is the one pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req_i | input | 1 | Hardware-detected exception request |
| hw_num_i | input | NW | Hardware exception number |
| sw_req_i | input | 1 | Software-raised exception request |
| sw_num_i | input | NW | Software exception number |
| sp_ld_i | input | 1 | Load SP from ld_val_i (idle only) |
| er_ld_i | input | 1 | Load ER from ld_val_i (idle only) |
| ld_val_i | input | AW | Value for register loads |
| mem_req_o | output | 1 | Stack memory request |
| mem_we_o | output | 1 | Write enable (1 = write) |
| mem_addr_o | output | AW | Stack memory word address |
| mem_wdata_o | output | AW | Write data |
| mem_rdata_i | input | AW | Read data, valid one cycle after a read request |
| pc_o | output | AW | Program counter |
| er_o | output | AW | Exception chain register |
| sp_o | output | AW | Stack pointer |
| busy_o | output | 1 | Unwind sequence in progress |
| done_o | output | 1 | One-cycle pulse at sequence end |
| fatal_o | output | 1 | Sticky flag: raise with empty chain |

## Verification
The checks assume the stack memory returns read data exactly one cycle after each read request. They also assume the environment does not load SP or ER in the same cycle that it raises an exception. The stimulus respects both limits. The bench memory model is a registered array that answers on the next edge. Register loads are always issued in idle cycles of their own, separate from the raise cycle. The one exception is the deliberate loads made during a busy sequence to exercise R9.

// File: rtl/exu_pkg.sv
package exu_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_RD_H  = 3'd1,
        S_WT_H  = 3'd2,
        S_WT_L  = 3'd3,
        S_PUSH  = 3'd4
    } exu_state_e;
endpackage

// File: rtl/exu_ctrl.sv
module exu_ctrl
    import exu_pkg::*;
#(
    parameter int AW = 16,
    parameter int NW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hw_req_i,
    input  logic [NW-1:0]   hw_num_i,
    input  logic            sw_req_i,
    input  logic [NW-1:0]   sw_num_i,
    input  logic            sp_ld_i,
    input  logic            er_ld_i,
    input  logic [AW-1:0]   ld_val_i,
    input  logic [AW-1:0]   mem_rdata_i,
    output exu_state_e      state_o,
    output logic [AW-1:0]   pc_o,
    output logic [AW-1:0]   er_o,
    output logic [AW-1:0]   sp_o,
    output logic [NW-1:0]   num_o,
    output logic            done_o,
    output logic            fatal_o
);
    typedef struct packed {
        exu_state_e    st;
        logic [AW-1:0] pc;
        logic [AW-1:0] er;
        logic [AW-1:0] sp;
        logic [NW-1:0] num;
        logic          done;
        logic          fatal;
    } ctx_t;

    ctx_t ctx_d, ctx_q;
    logic go;
    logic [NW-1:0] num_sel;

    assign go      = hw_req_i | sw_req_i;
    assign num_sel = hw_req_i ? hw_num_i : sw_num_i;

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        unique case (ctx_q.st)
            S_IDLE: begin
                if (sp_ld_i) ctx_d.sp = ld_val_i;
                if (er_ld_i) ctx_d.er = ld_val_i;
                if (go) begin
                    if (ctx_q.er == '0) begin
                        ctx_d.fatal = 1'b1;
                    end else begin
                        ctx_d.sp  = ctx_q.er;
                        ctx_d.num = num_sel;
                        ctx_d.st  = S_RD_H;
                    end
                end
            end
            S_RD_H: begin
                ctx_d.sp = ctx_q.sp + 1'b1;
                ctx_d.st = S_WT_H;
            end
            S_WT_H: begin
                ctx_d.pc = mem_rdata_i;
                ctx_d.sp = ctx_q.sp + 1'b1;
                ctx_d.st = S_WT_L;
            end
            S_WT_L: begin
                ctx_d.er = mem_rdata_i;
                ctx_d.st = S_PUSH;
            end
            S_PUSH: begin
                ctx_d.sp   = ctx_q.sp - 1'b1;
                ctx_d.done = 1'b1;
                ctx_d.st   = S_IDLE;
            end
            default: ctx_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '{st: S_IDLE, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign state_o = ctx_q.st;
    assign pc_o    = ctx_q.pc;
    assign er_o    = ctx_q.er;
    assign sp_o    = ctx_q.sp;
    assign num_o   = ctx_q.num;
    assign done_o  = ctx_q.done;
    assign fatal_o = ctx_q.fatal;

    // R2
    accept_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st == S_IDLE && go && ctx_q.er != '0)
        |=> (ctx_q.sp == $past(ctx_q.er) && ctx_q.st == S_RD_H));

    // R6
    seq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st == S_PUSH) |=> (ctx_q.st == S_IDLE && ctx_q.done));

    // R7
    fatal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_q.fatal |=> ctx_q.fatal);

    // R9
    er_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st != S_IDLE && ctx_q.st != S_WT_L) |=> $stable(ctx_q.er));

    // R8
    num_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st != S_IDLE) |=> $stable(ctx_q.num));
endmodule

// File: rtl/exu_memport.sv
module exu_memport
    import exu_pkg::*;
#(
    parameter int AW = 16,
    parameter int NW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  exu_state_e      state_i,
    input  logic [AW-1:0]   sp_i,
    input  logic [NW-1:0]   num_i,
    input  logic            fatal_i,
    output logic            mem_req_o,
    output logic            mem_we_o,
    output logic [AW-1:0]   mem_addr_o,
    output logic [AW-1:0]   mem_wdata_o
);
    localparam int PAD = AW - NW;

    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = sp_i;
        mem_wdata_o = {{PAD{1'b0}}, num_i};
        unique case (state_i)
            S_RD_H, S_WT_H: mem_req_o = 1'b1;
            S_PUSH: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = sp_i - 1'b1;
            end
            default: ;
        endcase
    end

    // R5
    we_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> mem_req_o);

    // R7
    fatal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fatal_i) |-> !mem_req_o);
endmodule

// File: rtl/exc_unwind.sv
module exc_unwind
    import exu_pkg::*;
#(
    parameter int AW = 16,
    parameter int NW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hw_req_i,
    input  logic [NW-1:0]   hw_num_i,
    input  logic            sw_req_i,
    input  logic [NW-1:0]   sw_num_i,
    input  logic            sp_ld_i,
    input  logic            er_ld_i,
    input  logic [AW-1:0]   ld_val_i,
    output logic            mem_req_o,
    output logic            mem_we_o,
    output logic [AW-1:0]   mem_addr_o,
    output logic [AW-1:0]   mem_wdata_o,
    input  logic [AW-1:0]   mem_rdata_i,
    output logic [AW-1:0]   pc_o,
    output logic [AW-1:0]   er_o,
    output logic [AW-1:0]   sp_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            fatal_o
);
    exu_state_e      state;
    logic [NW-1:0]   num;

    exu_ctrl #(.AW(AW), .NW(NW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_req_i   (hw_req_i),
        .hw_num_i   (hw_num_i),
        .sw_req_i   (sw_req_i),
        .sw_num_i   (sw_num_i),
        .sp_ld_i    (sp_ld_i),
        .er_ld_i    (er_ld_i),
        .ld_val_i   (ld_val_i),
        .mem_rdata_i(mem_rdata_i),
        .state_o    (state),
        .pc_o       (pc_o),
        .er_o       (er_o),
        .sp_o       (sp_o),
        .num_o      (num),
        .done_o     (done_o),
        .fatal_o    (fatal_o)
    );

    exu_memport #(.AW(AW), .NW(NW)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_i    (state),
        .sp_i       (sp_o),
        .num_i      (num),
        .fatal_i    (fatal_o),
        .mem_req_o  (mem_req_o),
        .mem_we_o   (mem_we_o),
        .mem_addr_o (mem_addr_o),
        .mem_wdata_o(mem_wdata_o)
    );

    assign busy_o = (state != S_IDLE);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

// File: tb/sim_exc_unwind.sv
module sim_exc_unwind;
    localparam int AW = 16;
    localparam int NW = 8;
    localparam int NV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_req_i = 0, sw_req_i = 0, sp_ld_i = 0, er_ld_i = 0;
    logic [NW-1:0] hw_num_i = '0, sw_num_i = '0;
    logic [AW-1:0] ld_val_i = '0;
    logic mem_req_o, mem_we_o, busy_o, done_o, fatal_o;
    logic [AW-1:0] mem_addr_o, mem_wdata_o, pc_o, er_o, sp_o;
    logic [AW-1:0] mem_rdata_i = '0;

    logic [AW-1:0] mem [0:255];
    logic          tb_we = 0;
    logic [7:0]    tb_addr = '0;
    logic [AW-1:0] tb_data = '0;
    int            req_cnt = 0;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    exc_unwind #(.AW(AW), .NW(NW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .hw_req_i(hw_req_i), .hw_num_i(hw_num_i),
        .sw_req_i(sw_req_i), .sw_num_i(sw_num_i),
        .sp_ld_i(sp_ld_i), .er_ld_i(er_ld_i), .ld_val_i(ld_val_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i),
        .pc_o(pc_o), .er_o(er_o), .sp_o(sp_o),
        .busy_o(busy_o), .done_o(done_o), .fatal_o(fatal_o)
    );

    always @(posedge clk) begin
        if (tb_we) mem[tb_addr] <= tb_data;
        if (mem_req_o) begin
            req_cnt <= req_cnt + 1;
            if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
            else          mem_rdata_i <= mem[mem_addr_o[7:0]];
        end
    end

    // chain record address, handler word, link word, number, source (1 = hw)
    localparam logic [AW-1:0] V_ER  [NV] = '{16'h0010, 16'h0030, 16'h007E, 16'h00F0};
    localparam logic [AW-1:0] V_HND [NV] = '{16'h1234, 16'hBEEF, 16'h0001, 16'hFFFE};
    localparam logic [AW-1:0] V_LNK [NV] = '{16'h0000, 16'h0010, 16'h0030, 16'h007E};
    localparam logic [NW-1:0] V_NUM [NV] = '{8'h05, 8'hA7, 8'hFF, 8'h00};
    localparam logic          V_HW  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [AW-1:0] d);
        @(negedge clk);
        tb_we = 1; tb_addr = a; tb_data = d;
        @(negedge clk);
        tb_we = 0;
    endtask

    task automatic load(input logic is_er, input logic [AW-1:0] v);
        @(negedge clk);
        ld_val_i = v;
        if (is_er) er_ld_i = 1; else sp_ld_i = 1;
        @(negedge clk);
        er_ld_i = 0; sp_ld_i = 0;
    endtask

    // raise one request, return busy cycle count, memory requests, done seen
    task automatic raise(input logic hw, input logic sw, input logic [NW-1:0] hn,
                         input logic [NW-1:0] sn, output int cyc, output int reqs,
                         output logic dn);
        int r0;
        @(negedge clk);
        r0 = req_cnt;
        hw_req_i = hw; sw_req_i = sw; hw_num_i = hn; sw_num_i = sn;
        @(negedge clk);
        hw_req_i = 0; sw_req_i = 0;
        cyc = 0;
        while (busy_o && cyc < 20) begin
            cyc++;
            @(negedge clk);
        end
        dn = done_o;
        @(negedge clk);
        reqs = req_cnt - r0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc, reqs;
        logic dn;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pc", pc_o, 0);
        chk("R1 er", er_o, 0);
        chk("R1 sp", sp_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 fatal", fatal_o, 0);
        chk("R1 mem_req", mem_req_o, 0);

        // vector table: R2 R3 R4 R5 R6 R10
        for (int i = 0; i < NV; i++) begin
            poke(V_ER[i][7:0], V_HND[i]);
            poke(V_ER[i][7:0] + 8'd1, V_LNK[i]);
            load(1'b0, 16'h00C0);
            load(1'b1, V_ER[i]);
            chk("R9 er idle load", er_o, V_ER[i]);
            @(negedge clk);
            hw_req_i = V_HW[i]; sw_req_i = !V_HW[i];
            hw_num_i = V_NUM[i]; sw_num_i = V_NUM[i];
            @(negedge clk);
            hw_req_i = 0; sw_req_i = 0;
            chk("R2 sp after accept", sp_o, V_ER[i]);
            chk("R2 busy", busy_o, 1);
            cyc = 1;
            while (busy_o && cyc < 20) begin
                @(negedge clk);
                if (busy_o) cyc++;
            end
            chk("R6 busy cycles", cyc, 4);
            chk("R6 done", done_o, 1);
            chk("R3 pc", pc_o, V_HND[i]);
            chk("R4 er", er_o, V_LNK[i]);
            chk("R5 sp", sp_o, V_ER[i] + 16'd1);
            chk("R5 pushed", mem[V_ER[i][7:0] + 8'd1], {8'h00, V_NUM[i]});
            @(negedge clk);
            chk("R6 done pulse", done_o, 0);
        end

        // R5 request count, R10 both sources, hardware wins
        poke(8'h50, 16'h4444);
        poke(8'h51, 16'h0060);
        load(1'b1, 16'h0050);
        raise(1'b1, 1'b1, 8'h11, 8'h22, cyc, reqs, dn);
        chk("R10 hw number pushed", mem[8'h51], 16'h0011);
        chk("R5 request count", reqs, 3);
        chk("R3 pc both", pc_o, 16'h4444);

        // R8 raise while busy ignored, R9 loads while busy ignored
        poke(8'h60, 16'h7777);
        poke(8'h61, 16'h0022);
        @(negedge clk);
        sw_req_i = 1; sw_num_i = 8'h33;
        @(negedge clk);
        sw_req_i = 0;
        hw_req_i = 1; hw_num_i = 8'h99;
        er_ld_i = 1; sp_ld_i = 1; ld_val_i = 16'h00AA;
        @(negedge clk);
        hw_req_i = 0; er_ld_i = 0; sp_ld_i = 0;
        while (busy_o) @(negedge clk);
        chk("R8 first number kept", mem[8'h61], 16'h0033);
        chk("R9 er not loaded while busy", er_o, 16'h0022);
        chk("R9 sp not loaded while busy", sp_o, 16'h0061);
        chk("R8 pc", pc_o, 16'h7777);

        // R7 empty chain
        load(1'b1, 16'h0000);
        load(1'b0, 16'h0040);
        raise(1'b1, 1'b0, 8'h0E, 8'h00, cyc, reqs, dn);
        chk("R7 fatal", fatal_o, 1);
        chk("R7 no memory access", reqs, 0);
        chk("R7 sp unchanged", sp_o, 16'h0040);
        chk("R7 pc unchanged", pc_o, 16'h7777);
        chk("R7 er unchanged", er_o, 16'h0000);
        chk("R7 not busy", cyc, 0);
        repeat (3) @(negedge clk);
        chk("R7 fatal sticky", fatal_o, 1);

        // R1 reset clears fatal
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 fatal after reset", fatal_o, 0);
        chk("R1 sp after reset", sp_o, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule